// File: doc/BRIEF.md
# Capture Interrupt Status and Mask Unit

This block gathers event pulses from up to four capture channels and from the shared error logic into one event status word. It drives a single registered interrupt line. Each channel reports five kinds of event: frame start, frame end, frame end confirmed, line end and line end confirmed. These land in groups of four bits, one group per kind and one bit per channel. The error sources are buffer overflow and four discard causes, and they occupy the bits above the channel groups.

Two kinds of configuration gate the events. Each channel has its own enable word, with one enable bit per event kind. A separate error gate word holds one bit per error source. An event whose gate is off does not set its status bit. Software reads the status word and writes ones to clear the bits it has handled. Writing back the value just read therefore clears exactly what was seen. If an event and a clear hit the same bit in the same cycle, the event wins.

The register port is a plain single-cycle write strobe with an address, and the read data is combinational on the same address. The unit has no sequencing of its own. All of its state is the status word, the gate words and the interrupt flop.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status word, every gate word and `irq` are all zero.
- R2: For channel x, a frame-start pulse sets status bit x, a frame-end pulse sets bit 4+x, and a frame-end-confirmed pulse sets bit 8+x.
- R3: For channel x, a line-end pulse sets status bit 12+x, and a line-end-confirmed pulse sets bit 16+x.
- R4: Error input bit 0 (overflow) sets status bit 20. Error input bits 1 to 4 (discard causes) set status bits 21 to 24.
- R5: The enable word of channel c is at address 2+c. Its bits 13 to 17 enable frame start, frame end, frame end confirmed, line end and line end confirmed, in that order. A pulse whose enable is 0 leaves its status bit unchanged.
- R6: The error gate word is at address 1. Its bit e gates error input e, and an error pulse with its gate at 0 sets nothing.
- R7: A write to address 0 clears each status bit whose data bit is 1 and leaves the others unchanged. Status bits with neither an event nor a clear hold their value.
- R8: An enabled event and a clear of the same bit in the same cycle leave that bit set.
- R9: `irq` is a registered OR of all status bits whose gate is on. It rises one cycle after a status bit sets, falls one cycle after the bits are cleared, and falls when the gate of a still-set bit is turned off, while the status bit remains.
- R10: Reading a channel enable word returns only bits 13 to 17, with zeros elsewhere. Reading the error gate word returns only bits 0 to 4. Reading address 0 returns the status in bits 0 to 24.
- R11: Writes to addresses 6 and 7 change no state, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_frame_start | input | NUM_CH | Frame-start pulse per channel |
| ev_frame_end | input | NUM_CH | Frame-end pulse per channel |
| ev_frame_done | input | NUM_CH | Frame-end-confirmed pulse per channel |
| ev_line_end | input | NUM_CH | Line-end pulse per channel |
| ev_line_done | input | NUM_CH | Line-end-confirmed pulse per channel |
| ev_error | input | ERR_W | Error pulses: bit 0 overflow, bits 1-4 discard causes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the collision of an event with a clearing write to the same bit. A design that gives the clear priority would lose the event, and the bench would read the bit back as zero.

It also targets the case where a gate is turned off while its status bit is still set. A design that latches `irq` or gates only the set path would keep `irq` high after that.

The bench further checks the one-cycle lag of `irq`, both after a set and after a clear; a combinational or two-stage interrupt shows up as an edge in the wrong cycle. Finally, it checks that partial clears and writes to unmapped addresses disturb no neighbouring bits.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

    // Per-kind groups are four bits wide regardless of the channel count.
    localparam int GROUP_W  = 4;
    localparam int KINDS    = 5;
    localparam int ERR_BASE = GROUP_W * KINDS;

    // Bit position of the first enable inside a channel enable word.
    localparam int CH_EN_LSB = 13;

    // Register addresses.
    localparam int ADDR_STATUS  = 0;
    localparam int ADDR_ERRGATE = 1;
    localparam int ADDR_CH_BASE = 2;

    // Event kinds, in group order inside the status word.
    typedef enum logic [2:0] {
        EV_FS      = 3'd0,
        EV_FE      = 3'd1,
        EV_FE_DONE = 3'd2,
        EV_LE      = 3'd3,
        EV_LE_DONE = 3'd4
    } ev_kind_e;

endpackage

// File: rtl/irq_status_w1c.sv
module irq_status_w1c #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);

    // One flop per bit; the set term is applied after the clear, so it wins.
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= (bit_q & ~clr_i[b]) | set_i[b];
            end
        end
        assign status_o[b] = bit_q;
    end

    // R7: a clear without a coincident set leaves the bit at zero
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((status_o & $past(clr_i & ~set_i)) == '0));

    // R8: a set bit is one on the next cycle, even under a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R7: untouched bits hold their value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (((status_o ^ $past(status_o)) & ~$past(set_i | clr_i)) == '0));

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_unit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ERR_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [ERR_W-1:0]          err_gate,
    output logic [NUM_CH*KINDS-1:0]   ch_en
);

    localparam int MAP_END = ADDR_CH_BASE + NUM_CH;

    logic [ERR_W-1:0] gate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else if (wr && addr == ADDR_W'(ADDR_ERRGATE)) begin
            gate_q <= wdata[ERR_W-1:0];
        end
    end
    assign err_gate = gate_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [KINDS-1:0] en_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
            end else if (wr && addr == ADDR_W'(ADDR_CH_BASE + c)) begin
                en_q <= wdata[CH_EN_LSB +: KINDS];
            end
        end
        assign ch_en[c*KINDS +: KINDS] = en_q;
    end

    // R6: a write to the error gate word takes effect on the next cycle
    p_gate_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(ADDR_ERRGATE)) |=> (err_gate == $past(wdata[ERR_W-1:0])));

    // R11: writes beyond the map leave all gate words alone
    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && int'(addr) >= MAP_END) |=> ($stable(err_gate) && $stable(ch_en)));

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_unit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ERR_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_frame_start,
    input  logic [NUM_CH-1:0] ev_frame_end,
    input  logic [NUM_CH-1:0] ev_frame_done,
    input  logic [NUM_CH-1:0] ev_line_end,
    input  logic [NUM_CH-1:0] ev_line_done,
    input  logic [ERR_W-1:0]  ev_error,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int STAT_W = ERR_BASE + ERR_W;

    logic [ERR_W-1:0]        err_gate;
    logic [NUM_CH*KINDS-1:0] ch_en;
    logic [STAT_W-1:0]       ev_vec;
    logic [STAT_W-1:0]       en_vec;
    logic [STAT_W-1:0]       clr_vec;
    logic [STAT_W-1:0]       status;
    logic                    irq_q;
    logic                    unused_wdata;

    assign unused_wdata = ^reg_wdata;

    irq_cfg_regs #(
        .NUM_CH (NUM_CH),
        .ERR_W  (ERR_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .err_gate (err_gate),
        .ch_en    (ch_en)
    );

    // Place events and their gates at kind*GROUP_W + channel.
    always_comb begin
        ev_vec = '0;
        en_vec = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            ev_vec[int'(EV_FS)      * GROUP_W + c] = ev_frame_start[c];
            ev_vec[int'(EV_FE)      * GROUP_W + c] = ev_frame_end[c];
            ev_vec[int'(EV_FE_DONE) * GROUP_W + c] = ev_frame_done[c];
            ev_vec[int'(EV_LE)      * GROUP_W + c] = ev_line_end[c];
            ev_vec[int'(EV_LE_DONE) * GROUP_W + c] = ev_line_done[c];
            for (int k = 0; k < KINDS; k++) begin
                en_vec[k*GROUP_W + c] = ch_en[c*KINDS + k];
            end
        end
        for (int e = 0; e < ERR_W; e++) begin
            ev_vec[ERR_BASE + e] = ev_error[e];
            en_vec[ERR_BASE + e] = err_gate[e];
        end
    end

    assign clr_vec = (reg_wr && reg_addr == ADDR_W'(ADDR_STATUS)) ?
                     reg_wdata[STAT_W-1:0] : '0;

    irq_status_w1c #(
        .W (STAT_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ev_vec & en_vec),
        .clr_i    (clr_vec),
        .status_o (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status & en_vec);
        end
    end
    assign irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_STATUS)) begin
            reg_rdata[STAT_W-1:0] = status;
        end else if (reg_addr == ADDR_W'(ADDR_ERRGATE)) begin
            reg_rdata[ERR_W-1:0] = err_gate;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(ADDR_CH_BASE + c)) begin
                reg_rdata[CH_EN_LSB +: KINDS] = ch_en[c*KINDS +: KINDS];
            end
        end
    end

    // R9: no interrupt without a status bit set on the cycle before
    p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(status != '0));

    // R5: a status bit only rises when its gate was on
    p_gated_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status & ~$past(status) & ~$past(en_vec)) == '0));

endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;

    localparam int CLK_P  = 10;
    localparam int NUM_CH = 4;
    localparam int ERR_W  = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] fs = '0, fe = '0, fd = '0, le = '0, ld = '0;
    logic [ERR_W-1:0]  er = '0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irq_status_unit #(
        .NUM_CH (NUM_CH),
        .ERR_W  (ERR_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_irq_status_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_frame_start (fs),
        .ev_frame_end   (fe),
        .ev_frame_done  (fd),
        .ev_line_end    (le),
        .ev_line_done   (ld),
        .ev_error       (er),
        .reg_wr         (wr),
        .reg_addr       (addr),
        .reg_wdata      (wdata),
        .reg_rdata      (rdata),
        .irq            (irq)
    );

    // Behavioural reference model
    logic [24:0] m_stat;
    logic [4:0]  m_gate;
    logic [4:0]  m_chen [4];
    logic        m_irq;

    function automatic logic [24:0] m_en();
        logic [24:0] v = '0;
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 5; k++) v[k*4 + c] = m_chen[c][k];
        for (int e = 0; e < 5; e++) v[20 + e] = m_gate[e];
        return v;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:                   return {7'd0, m_stat};
            3'd1:                   return {27'd0, m_gate};
            3'd2, 3'd3, 3'd4, 3'd5: return {14'd0, m_chen[a-2], 13'd0};
            default:                return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0;
            m_gate = '0;
            for (int c = 0; c < 4; c++) m_chen[c] = '0;
            m_irq = 1'b0;
        end else begin
            logic [24:0] en, evv, clr;
            en  = m_en();
            evv = {er, ld, le, fd, fe, fs};
            clr = (wr && addr == 3'd0) ? wdata[24:0] : '0;
            m_irq  = |(m_stat & en);
            m_stat = (m_stat & ~clr) | (evv & en);
            if (wr && addr == 3'd1) m_gate = wdata[4:0];
            if (wr && addr >= 3'd2 && addr <= 3'd5) m_chen[addr-2] = wdata[17:13];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " rdata"}, rdata, m_read(addr));
            chk({cur_req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        end
    end

    task automatic drive(input logic w, input logic [2:0] a, input logic [31:0] d,
                         input logic [3:0] p_fs, input logic [3:0] p_fe, input logic [3:0] p_fd,
                         input logic [3:0] p_le, input logic [3:0] p_ld, input logic [4:0] p_er);
        @(posedge clk);
        #1;
        wr = w; addr = a; wdata = d;
        fs = p_fs; fe = p_fe; fd = p_fd; le = p_le; ld = p_ld; er = p_er;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic chk_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        drive(1'b0, a, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        chk(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        #(CLK_P * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        cur_req = "R1";
        chk_rd("R1 status", 3'd0, 32'h0);
        chk_irq("R1 irq", 1'b0);
        chk_rd("R1 gate", 3'd1, 32'h0);
        chk_rd("R1 ch0", 3'd2, 32'h0);

        cur_req = "R10";
        wreg(3'd2, 32'hFFFF_FFFF);
        chk_rd("R10 ch0 readback", 3'd2, 32'h0003_E000);
        wreg(3'd1, 32'hFFFF_FFFF);
        chk_rd("R10 gate readback", 3'd1, 32'h0000_001F);
        wreg(3'd1, 32'h0);
        wreg(3'd3, 32'h0000_2000);

        cur_req = "R5";
        drive(1'b0, 3'd0, 0, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 5'h00);
        chk_rd("R5 per-channel enables", 3'd0, 32'h0001_1113);
        wreg(3'd0, 32'hFFFF_FFFF);

        cur_req = "R2";
        wreg(3'd4, 32'h0003_E000);
        wreg(3'd2, 32'h0);
        wreg(3'd3, 32'h0);
        drive(1'b0, 3'd0, 0, 4'b0100, 0, 0, 0, 0, 0);
        chk_rd("R2 frame start ch2", 3'd0, 32'h0000_0004);
        drive(1'b0, 3'd0, 0, 0, 4'b0100, 0, 0, 0, 0);
        chk_rd("R2 frame end ch2", 3'd0, 32'h0000_0044);
        drive(1'b0, 3'd0, 0, 0, 0, 4'b0100, 0, 0, 0);
        chk_rd("R2 frame done ch2", 3'd0, 32'h0000_0444);
        cur_req = "R3";
        drive(1'b0, 3'd0, 0, 0, 0, 0, 4'b0100, 0, 0);
        chk_rd("R3 line end ch2", 3'd0, 32'h0000_4444);
        drive(1'b0, 3'd0, 0, 0, 0, 0, 0, 4'b0100, 0);
        chk_rd("R3 line done ch2", 3'd0, 32'h0004_4444);

        cur_req = "R6";
        wreg(3'd1, 32'h0000_0009);
        drive(1'b0, 3'd0, 0, 0, 0, 0, 0, 0, 5'h1F);
        chk_rd("R6 error gate", 3'd0, 32'h0094_4444);
        cur_req = "R4";
        wreg(3'd1, 32'h0000_001F);
        wreg(3'd0, 32'h01F0_0000);
        drive(1'b0, 3'd0, 0, 0, 0, 0, 0, 0, 5'b00110);
        chk_rd("R4 discard bits", 3'd0, 32'h0064_4444);

        cur_req = "R7";
        wreg(3'd0, 32'h0004_4004);
        chk_rd("R7 partial clear", 3'd0, 32'h0060_0440);

        cur_req = "R8";
        drive(1'b1, 3'd0, 32'h0000_0044, 4'b0100, 0, 0, 0, 0, 0);
        chk_rd("R8 set beats clear", 3'd0, 32'h0060_0404);

        cur_req = "R9";
        chk_irq("R9 irq high", 1'b1);
        wreg(3'd0, 32'hFFFF_FFFF);
        chk_rd("R9 cleared", 3'd0, 32'h0);
        chk_irq("R9 irq lags clear", 1'b1);
        chk_rd("R9 idle", 3'd0, 32'h0);
        chk_irq("R9 irq low", 1'b0);
        drive(1'b0, 3'd0, 0, 4'b0100, 0, 0, 0, 0, 0);
        wreg(3'd4, 32'h0);
        drive(1'b0, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        chk_rd("R9 status kept", 3'd0, 32'h0000_0004);
        chk_irq("R9 gate off drops irq", 1'b0);

        cur_req = "R11";
        wreg(3'd2, 32'h0003_E000);
        wreg(3'd6, 32'hFFFF_FFFF);
        wreg(3'd7, 32'hFFFF_FFFF);
        chk_rd("R11 status", 3'd0, 32'h0000_0004);
        chk_rd("R11 gate", 3'd1, 32'h0000_001F);
        chk_rd("R11 ch0", 3'd2, 32'h0003_E000);
        chk_rd("R11 ch2", 3'd4, 32'h0);
        chk_rd("R11 read 6", 3'd6, 32'h0);

        cur_req = "R7 random";
        for (int i = 0; i < 600; i++) begin
            logic w;
            w = ($urandom_range(0, 3) == 0);
            drive(w, 3'($urandom_range(0, 7)), $urandom(),
                  4'($urandom()), 4'($urandom()), 4'($urandom()),
                  4'($urandom()), 4'($urandom()), 5'($urandom()));
        end
        drive(1'b0, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule